// File: doc/BRIEF.md
# Ring and Twisted-Ring Pattern Counter

This block is a short chain of D flip-flops that steps through a small fixed set of bit patterns instead of counting in binary. On every clock edge each stage copies the stage before it, and the first stage is fed from the last stage. A single mode input chooses how that feedback path works. With straight feedback, one hot bit circulates and the counter has a period equal to its width. With inverted feedback, the counter forms a twisted ring: it fills with ones, then drains them, and has a period of twice its width.

The first stage is the most significant bit of `cntOut`, so the four-bit pattern written `1000` means the first stage is set. A synchronous reset presets a pattern that fits the selected mode. A load strobe places any chosen pattern into the chain, which is how a ring sequence other than the preset one gets started. Illegal patterns are not corrected; they simply circulate.

Top module: `twist_ring_counter`

## Requirements
- R1: With `rst` high and `modeTwist` low at a rising edge, `cntOut` becomes `1000`, with only the first stage (MSB) set.
- R2: With `rst` high and `modeTwist` high at a rising edge, `cntOut` becomes `0000`.
- R3: With `rst` low and `loadEn` high at a rising edge, `cntOut` takes `loadPat` in either mode, and no shift happens in that cycle.
- R4: Reset takes priority over load: when `rst` and `loadEn` are both high, the mode-dependent preset of R1 or R2 is stored and `loadPat` is ignored.
- R5: In ring mode (`modeTwist` = 0), with `rst` and `loadEn` low, the next `cntOut` is `{cntOut[0], cntOut[3:1]}`, so the last stage feeds the first unchanged.
- R6: From the ring preset, the outputs step through `1000`, `0100`, `0010`, `0001` and come back to `1000` exactly four edges later.
- R7: In twisted mode (`modeTwist` = 1), with `rst` and `loadEn` low, the next `cntOut` is `{~cntOut[0], cntOut[3:1]}`.
- R8: From `0000` in twisted mode, the outputs step through `1000`, `1100`, `1110`, `1111`, `0111`, `0011`, `0001`, `0000`. These are eight distinct states, and the counter returns to its start exactly eight edges later.
- R9: Patterns outside a mode's legal sequence are not corrected: in ring mode `0000` stays `0000`, and any loaded pattern only rotates.
- R10: Changing `modeTwist` alters only the feedback applied at the next shift. The stored bits are not touched when the mode changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register samples on the rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the preset chosen by `modeTwist` |
| modeTwist | input | 1 | 0 selects straight ring feedback, 1 selects inverted (twisted) feedback |
| loadEn | input | 1 | Synchronous load strobe; replaces the shift for one cycle |
| loadPat | input | 4 | Pattern stored when `loadEn` is high; MSB goes to the first stage |
| cntOut | output | 4 | Stage outputs; MSB is the first stage, LSB the last |

## Verification
The properties assume that `rst` is high at the first rising edge, so the chain never shifts from an unknown value. They also assume that `rst`, `loadEn`, `modeTwist` and `loadPat` are stable around each rising edge. The stimulus holds reset from time zero. It changes every input only on the falling clock edge, half a period away from sampling. It reads `cntOut` one nanosecond after each rising edge, once the registered value has settled.

// File: rtl/twist_ring_pkg.sv
package twist_ring_pkg;
  // strobes handed from control to the datapath, one set per cycle
  typedef struct packed {
    logic presetRing;
    logic presetTwist;
    logic load;
    logic shift;
    logic invertFb;
  } ctrl_t;
endpackage

// File: rtl/counterCtrl.sv
module counterCtrl
  import twist_ring_pkg::*;
(
  input  logic  rst,
  input  logic  loadEn,
  input  logic  modeTwist,
  output ctrl_t strobes
);
  // priority: reset, then load, then shift
  always_comb begin
    strobes             = '0;
    strobes.invertFb    = modeTwist;
    if (rst) begin
      strobes.presetRing  = !modeTwist;
      strobes.presetTwist = modeTwist;
    end else if (loadEn) begin
      strobes.load        = 1'b1;
    end else begin
      strobes.shift       = 1'b1;
    end
  end
endmodule

// File: rtl/counterPath.sv
module counterPath
  import twist_ring_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  ctrl_t            strobes,
  input  logic [WIDTH-1:0] loadPat,
  output logic [WIDTH-1:0] stageQ
);
  localparam int FIRST = WIDTH - 1;
  localparam logic [WIDTH-1:0] RING_SEED = {1'b1, {(WIDTH-1){1'b0}}};

  logic             feedBit;
  logic [WIDTH-1:0] shiftIn;

  // last stage (bit 0) wraps to the first stage, optionally inverted
  assign feedBit = strobes.invertFb ? ~stageQ[0] : stageQ[0];

  generate
    for (genvar k = 0; k < WIDTH; k++) begin : g_stage
      if (k == FIRST) begin : g_head
        assign shiftIn[k] = feedBit;
      end else begin : g_body
        assign shiftIn[k] = stageQ[k+1];
      end

      always_ff @(posedge clk) begin
        if (strobes.presetRing)       stageQ[k] <= RING_SEED[k];
        else if (strobes.presetTwist) stageQ[k] <= 1'b0;
        else if (strobes.load)        stageQ[k] <= loadPat[k];
        else if (strobes.shift)       stageQ[k] <= shiftIn[k];
      end
    end
  endgenerate
endmodule

// File: rtl/twist_ring_counter.sv
module twist_ring_counter
  import twist_ring_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeTwist,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadPat,
  output logic [WIDTH-1:0] cntOut
);
  ctrl_t strobes;

  counterCtrl u_ctrl (
    .rst       (rst),
    .loadEn    (loadEn),
    .modeTwist (modeTwist),
    .strobes   (strobes)
  );

  counterPath #(.WIDTH(WIDTH)) u_path (
    .clk     (clk),
    .strobes (strobes),
    .loadPat (loadPat),
    .stageQ  (cntOut)
  );
endmodule

// File: rtl/twist_ring_checker.sv
module twist_ring_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             modeTwist,
  input logic             loadEn,
  input logic [WIDTH-1:0] loadPat,
  input logic [WIDTH-1:0] cntOut
);
  localparam logic [WIDTH-1:0] RING_SEED = {1'b1, {(WIDTH-1){1'b0}}};

  AST_RST_RING: assert property (@(posedge clk) (rst && !modeTwist) |=> cntOut == RING_SEED); // R1
  AST_RST_TWIST: assert property (@(posedge clk) (rst && modeTwist) |=> cntOut == '0); // R2
  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (rst) loadEn |=> cntOut == $past(loadPat)); // R3
  AST_RST_OVER_LOAD: assert property (@(posedge clk) (rst && loadEn && loadPat != RING_SEED) |=> cntOut != $past(loadPat) || cntOut == '0); // R4
  AST_RING_STEP: assert property (@(posedge clk) disable iff (rst) (!loadEn && !modeTwist) |=> cntOut == {$past(cntOut[0]), $past(cntOut[WIDTH-1:1])}); // R5
  AST_TWIST_STEP: assert property (@(posedge clk) disable iff (rst) (!loadEn && modeTwist) |=> cntOut == {~$past(cntOut[0]), $past(cntOut[WIDTH-1:1])}); // R7
  AST_RING_ONEHOT_KEPT: assert property (@(posedge clk) disable iff (rst) (!loadEn && !modeTwist && $onehot0(cntOut)) |=> $onehot0(cntOut)); // R9
endmodule

bind twist_ring_counter twist_ring_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .modeTwist (modeTwist),
  .loadEn    (loadEn),
  .loadPat   (loadPat),
  .cntOut    (cntOut)
);

// File: tb/sim_twist_ring_counter.sv
`timescale 1ns/1ps
module sim_twist_ring_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeTwist = 1'b0;
  logic       loadEn = 1'b0;
  logic [3:0] loadPat = 4'b0000;
  logic [3:0] cntOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  twist_ring_counter #(.WIDTH(4)) u0 (
    .clk(clk), .rst(rst), .modeTwist(modeTwist),
    .loadEn(loadEn), .loadPat(loadPat), .cntOut(cntOut)
  );

  // row: {rst, loadEn, modeTwist, loadPat[3:0], expect[3:0]}
  localparam int NV = 22;
  localparam logic [10:0] VEC [NV] = '{
    {3'b100, 4'b0000, 4'b1000},  // R1 ring preset
    {3'b000, 4'b0000, 4'b0100},  // R5/R6
    {3'b000, 4'b0000, 4'b0010},  // R6
    {3'b000, 4'b0000, 4'b0001},  // R6
    {3'b000, 4'b0000, 4'b1000},  // R6 wraps after four
    {3'b101, 4'b0000, 4'b0000},  // R2 twisted preset
    {3'b001, 4'b0000, 4'b1000},  // R8
    {3'b001, 4'b0000, 4'b1100},  // R8
    {3'b001, 4'b0000, 4'b1110},  // R8
    {3'b001, 4'b0000, 4'b1111},  // R8
    {3'b001, 4'b0000, 4'b0111},  // R8
    {3'b001, 4'b0000, 4'b0011},  // R8
    {3'b001, 4'b0000, 4'b0001},  // R8
    {3'b001, 4'b0000, 4'b0000},  // R8 wraps after eight
    {3'b011, 4'b1010, 4'b1010},  // R3 load in twisted mode
    {3'b001, 4'b0000, 4'b1101},  // R7
    {3'b000, 4'b0000, 4'b1110},  // R10 mode switch, bits kept
    {3'b000, 4'b0000, 4'b0111},  // R5
    {3'b110, 4'b0110, 4'b1000},  // R4 reset beats load
    {3'b010, 4'b0000, 4'b0000},  // R3 load in ring mode
    {3'b000, 4'b0000, 4'b0000},  // R9 empty ring stays empty
    {3'b000, 4'b0000, 4'b0000}   // R9
  };
  localparam int VREQ [NV] = '{1,5,6,6,6,2,8,8,8,8,8,8,8,8,3,7,10,5,4,3,9,9};

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive at falling edge, then look 1 ns after the next rising edge
  task automatic step(input logic r, input logic l, input logic m, input logic [3:0] p);
    @(negedge clk);
    rst = r; loadEn = l; modeTwist = m; loadPat = p;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] startPat;
    logic [3:0] seen [8];
    int period;
    // R1 reset state
    step(1'b1, 1'b0, 1'b0, 4'b0000);
    check("R1 reset state", cntOut, 4'b1000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
      check($sformatf("R%0d vector %0d", VREQ[i], i), cntOut, VEC[i][3:0]);
    end

    // R6 period of a loaded one-hot pattern is exactly four
    step(1'b0, 1'b1, 1'b0, 4'b0010);
    startPat = cntOut;
    period = 0;
    for (int i = 1; i <= 8; i++) begin
      step(1'b0, 1'b0, 1'b0, 4'b0000);
      if (period == 0 && cntOut == startPat) period = i;
    end
    check("R6 ring period", 4'(period), 4'd4);

    // R8 twisted period from 0000 is eight with distinct states
    step(1'b1, 1'b0, 1'b1, 4'b0000);
    startPat = cntOut;
    period = 0;
    for (int i = 1; i <= 8; i++) begin
      step(1'b0, 1'b0, 1'b1, 4'b0000);
      seen[i-1] = cntOut;
      if (period == 0 && cntOut == startPat) period = i;
    end
    check("R8 twisted period", 4'(period), 4'd8);
    for (int a = 0; a < 8; a++)
      for (int b = a + 1; b < 8; b++)
        if (seen[a] == seen[b]) check("R8 distinct states", seen[b], ~seen[a]);

    // R9 illegal ring pattern 1010 just rotates
    step(1'b0, 1'b1, 1'b0, 4'b1010);
    step(1'b0, 1'b0, 1'b0, 4'b0000);
    check("R9 two-hot rotates", cntOut, 4'b0101);
    step(1'b0, 1'b0, 1'b0, 4'b0000);
    check("R9 two-hot rotates back", cntOut, 4'b1010);

    // R3 load overrides shift mid-sequence
    step(1'b0, 1'b1, 1'b1, 4'b0110);
    check("R3 load overrides twisted shift", cntOut, 4'b0110);

    // R2 reset from a non-zero state in twisted mode
    step(1'b1, 1'b1, 1'b1, 4'b1111);
    check("R2 and R4 twisted reset beats load", cntOut, 4'b0000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule